// File: doc/BRIEF.md
# Parallel Bus Phase Sequencer

This block is the initiator-side controller for a shared parallel bus with up to eight devices. The host hands it a request to talk to a target ID over a valid/ready handshake. The sequencer waits until the bus has been idle for a programmable number of cycles. It then contends for ownership by driving its own ID bit onto the data lines. If no higher ID is present, it selects the target and follows the information phases that the target signals on its message, control/data and direction lines.

A target may give up the bus partway through a command. The sequencer then records that a reconnection is owed and answers the target's later reselection. A command counts as finished when the target releases the bus directly after a status phase that was followed by an inbound message. A selection that draws no response within a programmable number of cycles is abandoned and flagged. A synchronous bus reset input returns the sequencer to the idle phase from anywhere. It also discards both the held request and any owed reconnection.

Handshake rules: `cmd_ready_o` is high only when no request is held and the bus reset is low. A request transfers on a clock edge where both `cmd_valid_i` and `cmd_ready_o` are high. Once accepted, the request is held internally until it either connects or times out, so the host never needs to hold `cmd_valid_i` longer than one transfer. The bus-line inputs carry only what the other devices drive; the sequencer adds its own drive internally.

Top module: `bus_phase_seq`

## Requirements
- R1: While reset is held, `phase_o` is 0 (idle), `busy_o`, `select_o` and all status pulses are 0, `data_o` is 0, and `cmd_ready_o` is 1.
- R2: When `bus_rst_i` is high at a clock edge, the sequencer is idle after that edge with `busy_o` and `select_o` low. Any held request and any owed reconnection are discarded, so a later reselection is ignored.
- R3: Contention starts (`phase_o` = 1, `busy_o` = 1, `data_o` = own ID bit only) on the edge after the bus has been seen with busy and select both low for `cfg_free_cyc` consecutive edges while a request is held. Any busy or select activity restarts that count.
- R4: Contention lasts one cycle. If another device shows a data bit above the own ID, or drives select, the sequencer returns to idle and pulses `lost_o` for one cycle. It keeps the request and contends again after a new idle window. Otherwise it moves to selection, so ID 7 can never lose on data bits.
- R5: During selection (`phase_o` = 2), `select_o` = 1, `busy_o` = 0 and `data_o` holds the own ID bit OR the target ID bit. The target raising busy moves the sequencer to the information phases.
- R6: If busy is not seen within `cfg_sel_tmo` cycles of selection, the sequencer returns to idle, pulses `sel_err_o` for one cycle and drops the request.
- R7: While connected, `phase_o` decodes the target lines. Message high gives 7 (message). Otherwise control/data high gives 6 (status) with direction high, or 4 (command) with direction low. Otherwise the code is 5 (data). `xfer_in_o` equals the direction line only while connected.
- R8: When the target releases busy while connected, `done_o` pulses for one cycle only if a status phase occurred in this connection and the last phase before release was an inbound message.
- R9: Any other release while connected pulses `disc_o` for one cycle and records that a reconnection is owed.
- R10: While idle and a reconnection is owed, a target driving select and direction high, with busy low and the own ID bit set, moves the sequencer to phase 3 with `busy_o` = 1. When select drops, the sequencer enters the information phases and pulses `resel_o`. With no reconnection owed, this stimulus is ignored.
- R11: `cmd_ready_o` goes low after a request is accepted. It returns high only after the request connects, times out, or a bus reset occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Synchronous bus reset, returns to idle |
| cfg_my_id | input | 3 | Own device ID |
| cfg_free_cyc | input | 8 | Idle cycles required before contending |
| cfg_sel_tmo | input | 12 | Selection response limit in cycles |
| cmd_valid_i | input | 1 | Host request valid |
| cmd_ready_o | output | 1 | Request can be accepted |
| cmd_target_i | input | 3 | Target ID of the request |
| bus_busy_i | input | 1 | Busy line as driven by other devices |
| bus_sel_i | input | 1 | Select line as driven by other devices |
| tgt_msg_i | input | 1 | Target message line |
| tgt_cd_i | input | 1 | Target control/data line |
| tgt_io_i | input | 1 | Target direction line, high means toward the initiator |
| bus_data_i | input | 8 | Data lines as driven by other devices |
| busy_o | output | 1 | Own busy drive |
| select_o | output | 1 | Own select drive |
| data_o | output | 8 | Own data-line drive |
| phase_o | output | 3 | Current phase code |
| xfer_in_o | output | 1 | Inbound transfer while connected |
| lost_o | output | 1 | One-cycle pulse: contention lost |
| sel_err_o | output | 1 | One-cycle pulse: selection timed out |
| done_o | output | 1 | One-cycle pulse: command completed |
| disc_o | output | 1 | One-cycle pulse: target disconnected early |
| resel_o | output | 1 | One-cycle pulse: reconnection accepted |

## Verification
A wrong internal state shows at the ports on the very next cycle, because the line drives and `phase_o` are decoded straight from the state register. A missed withdrawal appears as `busy_o` staying high or `select_o` rising against a higher contender. A stale window count appears as contention starting a cycle early or late. Faults in completion tracking are subtler: a status flag or last-phase memory that is not cleared only shows when busy drops. At that point `done_o` and `disc_o` swap, and a reselection that should be ignored raises `busy_o` within one cycle.

// File: rtl/bps_pkg.sv
package bps_pkg;

  typedef enum logic [2:0] {
    PH_FREE  = 3'd0,
    PH_ARB   = 3'd1,
    PH_SEL   = 3'd2,
    PH_RESEL = 3'd3,
    PH_CMD   = 3'd4,
    PH_DATA  = 3'd5,
    PH_STAT  = 3'd6,
    PH_MSG   = 3'd7
  } phase_e;

  typedef enum logic [2:0] {
    ST_FREE,
    ST_ARB,
    ST_SEL,
    ST_RESEL,
    ST_INFO
  } st_e;

endpackage

// File: rtl/bps_sat_counter.sv
module bps_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && cnt != MAXV) begin
      cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/bps_arb_judge.sv
module bps_arb_judge #(
  parameter int N_DEV = 8,
  parameter int ID_W  = 3
) (
  input  logic [N_DEV-1:0] bus_bits,
  input  logic [ID_W-1:0]  own_id,
  output logic             outbid
);

  logic [N_DEV-1:0] above;

  for (genvar g = 0; g < N_DEV; g++) begin : g_cmp
    localparam logic [ID_W:0] POS = (ID_W+1)'(g);
    assign above[g] = bus_bits[g] && (POS > {1'b0, own_id});
  end

  assign outbid = |above;

endmodule

// File: rtl/bps_info_decode.sv
module bps_info_decode
  import bps_pkg::*;
(
  input  logic   msg,
  input  logic   cd,
  input  logic   io,
  output phase_e ph,
  output logic   dir_in
);

  always_comb begin
    if (msg) begin
      ph = PH_MSG;
    end else if (cd) begin
      ph = io ? PH_STAT : PH_CMD;
    end else begin
      ph = PH_DATA;
    end
  end

  assign dir_in = io;

endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
  import bps_pkg::*;
#(
  parameter int N_DEV  = 8,
  parameter int FREE_W = 8,
  parameter int TMO_W  = 12,
  localparam int ID_W  = $clog2(N_DEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst_i,
  input  logic [ID_W-1:0]   cfg_my_id,
  input  logic [FREE_W-1:0] cfg_free_cyc,
  input  logic [TMO_W-1:0]  cfg_sel_tmo,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ID_W-1:0]   cmd_target_i,
  input  logic              bus_busy_i,
  input  logic              bus_sel_i,
  input  logic              tgt_msg_i,
  input  logic              tgt_cd_i,
  input  logic              tgt_io_i,
  input  logic [N_DEV-1:0]  bus_data_i,
  output logic              busy_o,
  output logic              select_o,
  output logic [N_DEV-1:0]  data_o,
  output logic [2:0]        phase_o,
  output logic              xfer_in_o,
  output logic              lost_o,
  output logic              sel_err_o,
  output logic              done_o,
  output logic              disc_o,
  output logic              resel_o
);

  st_e               st_q, st_d;
  logic              req_q;
  logic [ID_W-1:0]   tgt_q;
  logic              pend_q;
  logic              stat_seen_q;
  logic              last_min_q;
  logic              lost_q, err_q, done_q, disc_q, resel_q;

  logic [N_DEV-1:0]  my_bit, tgt_bit;
  logic              line_busy;
  logic [FREE_W-1:0] free_cnt;
  logic [TMO_W-1:0]  sel_cnt;
  logic [TMO_W:0]    sel_next;
  logic              free_ok, tmo_hit, outbid, resel_hit;
  phase_e            ph_info;
  logic              dir_in;
  phase_e            ph_out;

  // one-hot images of the own and target IDs
  always_comb begin
    my_bit  = '0;
    tgt_bit = '0;
    my_bit[cfg_my_id] = 1'b1;
    tgt_bit[tgt_q]    = 1'b1;
  end

  assign line_busy = bus_busy_i | bus_sel_i | busy_o | select_o;

  // idle-window counter: restarts on any line activity
  bps_sat_counter #(.W(FREE_W)) i_free_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (line_busy | bus_rst_i),
    .inc   (1'b1),
    .cnt   (free_cnt)
  );

  // selection response counter: held at zero outside selection
  bps_sat_counter #(.W(TMO_W)) i_sel_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != ST_SEL),
    .inc   (1'b1),
    .cnt   (sel_cnt)
  );

  bps_arb_judge #(.N_DEV(N_DEV), .ID_W(ID_W)) i_judge (
    .bus_bits (bus_data_i),
    .own_id   (cfg_my_id),
    .outbid   (outbid)
  );

  bps_info_decode i_decode (
    .msg    (tgt_msg_i),
    .cd     (tgt_cd_i),
    .io     (tgt_io_i),
    .ph     (ph_info),
    .dir_in (dir_in)
  );

  assign free_ok   = free_cnt >= cfg_free_cyc;
  assign sel_next  = {1'b0, sel_cnt} + (TMO_W+1)'(1);
  assign tmo_hit   = sel_next >= {1'b0, cfg_sel_tmo};
  assign resel_hit = pend_q && bus_sel_i && tgt_io_i && !bus_busy_i &&
                     bus_data_i[cfg_my_id];

  // next-state selection
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FREE: begin
        if (resel_hit) begin
          st_d = ST_RESEL;
        end else if (req_q && free_ok && !bus_busy_i && !bus_sel_i) begin
          st_d = ST_ARB;
        end
      end
      ST_ARB: begin
        st_d = (outbid || bus_sel_i) ? ST_FREE : ST_SEL;
      end
      ST_SEL: begin
        if (bus_busy_i) begin
          st_d = ST_INFO;
        end else if (tmo_hit) begin
          st_d = ST_FREE;
        end
      end
      ST_RESEL: begin
        if (!bus_sel_i) st_d = ST_INFO;
      end
      ST_INFO: begin
        if (!bus_busy_i) st_d = ST_FREE;
      end
      default: st_d = ST_FREE;
    endcase
  end

  // state, request, reconnection and completion tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_FREE;
      req_q       <= 1'b0;
      tgt_q       <= '0;
      pend_q      <= 1'b0;
      stat_seen_q <= 1'b0;
      last_min_q  <= 1'b0;
      lost_q      <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      disc_q      <= 1'b0;
      resel_q     <= 1'b0;
    end else begin
      lost_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      disc_q  <= 1'b0;
      resel_q <= 1'b0;
      if (bus_rst_i) begin
        st_q   <= ST_FREE;
        req_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        st_q <= st_d;
        if (cmd_valid_i && !req_q) begin
          req_q <= 1'b1;
          tgt_q <= cmd_target_i;
        end
        unique case (st_q)
          ST_ARB: begin
            if (outbid || bus_sel_i) lost_q <= 1'b1;
          end
          ST_SEL: begin
            if (bus_busy_i) begin
              req_q       <= 1'b0;
              stat_seen_q <= 1'b0;
              last_min_q  <= 1'b0;
            end else if (tmo_hit) begin
              req_q <= 1'b0;
              err_q <= 1'b1;
            end
          end
          ST_RESEL: begin
            if (!bus_sel_i) begin
              resel_q     <= 1'b1;
              pend_q      <= 1'b0;
              stat_seen_q <= 1'b0;
              last_min_q  <= 1'b0;
            end
          end
          ST_INFO: begin
            if (bus_busy_i) begin
              if (ph_info == PH_STAT) stat_seen_q <= 1'b1;
              last_min_q <= (ph_info == PH_MSG) && dir_in;
            end else if (stat_seen_q && last_min_q) begin
              done_q <= 1'b1;
            end else begin
              disc_q <= 1'b1;
              pend_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // line drives and phase report
  always_comb begin
    busy_o    = 1'b0;
    select_o  = 1'b0;
    data_o    = '0;
    xfer_in_o = 1'b0;
    ph_out    = PH_FREE;
    unique case (st_q)
      ST_ARB: begin
        busy_o = 1'b1;
        data_o = my_bit;
        ph_out = PH_ARB;
      end
      ST_SEL: begin
        select_o = 1'b1;
        data_o   = my_bit | tgt_bit;
        ph_out   = PH_SEL;
      end
      ST_RESEL: begin
        busy_o = 1'b1;
        ph_out = PH_RESEL;
      end
      ST_INFO: begin
        xfer_in_o = dir_in;
        ph_out    = ph_info;
      end
      default: ph_out = PH_FREE;
    endcase
  end

  assign phase_o     = ph_out;
  assign cmd_ready_o = !req_q && !bus_rst_i;
  assign lost_o      = lost_q;
  assign sel_err_o   = err_q;
  assign done_o      = done_q;
  assign disc_o      = disc_q;
  assign resel_o     = resel_q;

endmodule

// File: rtl/bps_seq_chk.sv
module bps_seq_chk
  import bps_pkg::*;
#(
  parameter int N_DEV = 8,
  parameter int ID_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rst_i,
  input logic             bus_busy_i,
  input logic             bus_sel_i,
  input logic             cmd_valid_i,
  input logic             cmd_ready_o,
  input logic [ID_W-1:0]  cfg_my_id,
  input logic             busy_o,
  input logic             select_o,
  input logic [N_DEV-1:0] data_o,
  input logic [2:0]       phase_o,
  input logic             xfer_in_o,
  input logic             lost_o,
  input logic             sel_err_o,
  input logic             resel_o
);

  // R2
  bus_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> (phase_o == PH_FREE && !busy_o && !select_o));

  // R3
  arb_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_ARB) |-> $past(!bus_busy_i && !bus_sel_i));

  // R3
  arb_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_ARB) |-> ($countones(data_o) == 1 && busy_o));

  // R4
  lost_from_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> ($past(phase_o == PH_ARB) && !busy_o));

  // R5
  sel_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    select_o |-> (!busy_o && data_o[cfg_my_id]));

  // R6
  tmo_from_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err_o |-> ($past(phase_o == PH_SEL) && !select_o));

  // R7
  cmd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_CMD) |-> !xfer_in_o);

  // R10
  resel_from_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resel_o |-> $past(phase_o == PH_RESEL));

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

endmodule

bind bus_phase_seq bps_seq_chk #(.N_DEV(N_DEV), .ID_W(ID_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rst_i   (bus_rst_i),
  .bus_busy_i  (bus_busy_i),
  .bus_sel_i   (bus_sel_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cfg_my_id   (cfg_my_id),
  .busy_o      (busy_o),
  .select_o    (select_o),
  .data_o      (data_o),
  .phase_o     (phase_o),
  .xfer_in_o   (xfer_in_o),
  .lost_o      (lost_o),
  .sel_err_o   (sel_err_o),
  .resel_o     (resel_o)
);

// File: tb/test_bus_phase_seq.sv
`timescale 1ns/100ps
module test_bus_phase_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rst_i = 1'b0;
  logic [2:0]  cfg_my_id = 3'd3;
  logic [7:0]  cfg_free_cyc = 8'd2;
  logic [11:0] cfg_sel_tmo = 12'd4;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic [2:0]  cmd_target_i = 3'd5;
  logic        bus_busy_i = 1'b0, bus_sel_i = 1'b0;
  logic        tgt_msg_i = 1'b0, tgt_cd_i = 1'b0, tgt_io_i = 1'b0;
  logic [7:0]  bus_data_i = 8'h00;
  logic        busy_o, select_o, xfer_in_o;
  logic [7:0]  data_o;
  logic [2:0]  phase_o;
  logic        lost_o, sel_err_o, done_o, disc_o, resel_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bus_phase_seq i_bus_phase_seq (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i),
    .cfg_my_id(cfg_my_id), .cfg_free_cyc(cfg_free_cyc), .cfg_sel_tmo(cfg_sel_tmo),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_target_i(cmd_target_i),
    .bus_busy_i(bus_busy_i), .bus_sel_i(bus_sel_i),
    .tgt_msg_i(tgt_msg_i), .tgt_cd_i(tgt_cd_i), .tgt_io_i(tgt_io_i),
    .bus_data_i(bus_data_i),
    .busy_o(busy_o), .select_o(select_o), .data_o(data_o), .phase_o(phase_o),
    .xfer_in_o(xfer_in_o), .lost_o(lost_o), .sel_err_o(sel_err_o),
    .done_o(done_o), .disc_o(disc_o), .resel_o(resel_o)
  );

  // vector: [31:26] {valid,busy,sel,msg,cd,io} [25:18] data_in
  //         [17:15] phase [14:8] {busy_o,select_o,xfer_in,done,disc,resel,lost} [7:0] data_o
  localparam int NV = 23;
  localparam logic [31:0] VEC [NV] = '{
    {6'b100000, 8'h00, 3'd0, 7'b0000000, 8'h00},  // accept request
    {6'b000000, 8'h00, 3'd0, 7'b0000000, 8'h00},  // idle window
    {6'b000000, 8'h00, 3'd1, 7'b1000000, 8'h08},  // contend
    {6'b010000, 8'h01, 3'd2, 7'b0100000, 8'h28},  // lower contender, select
    {6'b000000, 8'h00, 3'd2, 7'b0100000, 8'h28},  // waiting on target
    {6'b010010, 8'h00, 3'd4, 7'b0000000, 8'h00},  // command
    {6'b010001, 8'h00, 3'd5, 7'b0010000, 8'h00},  // data in
    {6'b010011, 8'h00, 3'd6, 7'b0010000, 8'h00},  // status
    {6'b010111, 8'h00, 3'd7, 7'b0010000, 8'h00},  // message in
    {6'b000000, 8'h00, 3'd0, 7'b0001000, 8'h00},  // release: done
    {6'b100000, 8'h00, 3'd0, 7'b0000000, 8'h00},  // second request
    {6'b000000, 8'h00, 3'd1, 7'b1000000, 8'h08},
    {6'b000000, 8'h00, 3'd2, 7'b0100000, 8'h28},
    {6'b010010, 8'h00, 3'd4, 7'b0000000, 8'h00},
    {6'b010111, 8'h00, 3'd7, 7'b0010000, 8'h00},  // message in, no status
    {6'b000000, 8'h00, 3'd0, 7'b0000100, 8'h00},  // release: disconnect
    {6'b001001, 8'h28, 3'd3, 7'b1000000, 8'h00},  // reselection answered
    {6'b001001, 8'h28, 3'd3, 7'b1000000, 8'h00},
    {6'b010001, 8'h00, 3'd5, 7'b0010010, 8'h00},  // reconnected, data in
    {6'b010011, 8'h00, 3'd6, 7'b0010000, 8'h00},
    {6'b010111, 8'h00, 3'd7, 7'b0010000, 8'h00},
    {6'b000000, 8'h00, 3'd0, 7'b0001000, 8'h00},  // done after reconnection
    {6'b000000, 8'h00, 3'd0, 7'b0000000, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cmd_valid_i = 1'b0; bus_busy_i = 1'b0; bus_sel_i = 1'b0;
    tgt_msg_i = 1'b0; tgt_cd_i = 1'b0; tgt_io_i = 1'b0; bus_data_i = 8'h00;
    bus_rst_i = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  // from a fresh reset with an idle bus: request, then contention after 3 edges
  task automatic to_arb();
    cmd_valid_i = 1'b1;
    tick(1);
    cmd_valid_i = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    idle_inputs();
    rst_n = 1'b0;
    tick(2);
    chk("R1 reset phase/drives", {phase_o, busy_o, select_o, data_o},
        {3'd0, 1'b0, 1'b0, 8'h00});
    chk("R1 reset pulses/ready", {lost_o, sel_err_o, done_o, disc_o, resel_o, cmd_ready_o},
        6'b000001);
    rst_n = 1'b1;

    // table: full command, disconnect, reselection, completion (R3 R4 R5 R7 R8 R9 R10)
    for (int i = 0; i < NV; i++) begin
      {cmd_valid_i, bus_busy_i, bus_sel_i, tgt_msg_i, tgt_cd_i, tgt_io_i} = VEC[i][31:26];
      bus_data_i = VEC[i][25:18];
      tick(1);
      chk($sformatf("R3 R5 R7 R8 R9 R10 vector %0d", i),
          {phase_o, busy_o, select_o, xfer_in_o, done_o, disc_o, resel_o, lost_o, data_o},
          {VEC[i][17:0]});
    end
    idle_inputs();

    // R3 hold-off while another device is busy; R11 ready drops
    do_reset();
    cmd_valid_i = 1'b1; bus_busy_i = 1'b1;
    tick(1);
    cmd_valid_i = 1'b0;
    chk("R11 ready low after accept", cmd_ready_o, 1'b0);
    tick(5);
    chk("R3 no contention while busy", {phase_o, busy_o}, {3'd0, 1'b0});
    bus_busy_i = 1'b0;
    tick(2);
    chk("R3 window not yet elapsed", phase_o, 3'd0);
    tick(1);
    chk("R3 contention after window", {phase_o, data_o}, {3'd1, 8'h08});

    // R4 loss to higher ID, retry
    bus_data_i = 8'h40; bus_busy_i = 1'b1;
    tick(1);
    chk("R4 withdraw on higher ID", {phase_o, busy_o, lost_o, cmd_ready_o}, {3'd0, 1'b0, 1'b1, 1'b0});
    bus_data_i = 8'h00; bus_busy_i = 1'b0;
    tick(2);
    chk("R4 waits new window", {phase_o, lost_o}, {3'd0, 1'b0});
    tick(1);
    chk("R4 retries", phase_o, 3'd1);

    // R6 selection timeout
    tick(1);
    chk("R6 selection entered", {phase_o, select_o}, {3'd2, 1'b1});
    tick(3);
    chk("R6 still selecting", {phase_o, sel_err_o}, {3'd2, 1'b0});
    tick(1);
    chk("R6 timeout", {phase_o, select_o, sel_err_o, cmd_ready_o}, {3'd0, 1'b0, 1'b1, 1'b1});
    tick(1);
    chk("R6 pulse one cycle", sel_err_o, 1'b0);

    // R4 loss when select already driven
    do_reset();
    to_arb();
    bus_sel_i = 1'b1;
    tick(1);
    chk("R4 withdraw on select", {phase_o, lost_o}, {3'd0, 1'b1});
    bus_sel_i = 1'b0;

    // R4 highest ID wins, R2 bus reset from selection
    do_reset();
    cfg_my_id = 3'd7;
    to_arb();
    bus_data_i = 8'h40; bus_busy_i = 1'b1;
    tick(1);
    chk("R4 ID 7 wins", {phase_o, data_o}, {3'd2, 8'hA0});
    bus_data_i = 8'h00; bus_busy_i = 1'b0;
    bus_rst_i = 1'b1;
    tick(1);
    chk("R2 reset from selection", {phase_o, select_o, busy_o}, {3'd0, 1'b0, 1'b0});
    bus_rst_i = 1'b0;
    tick(1);
    chk("R2 request dropped", {cmd_ready_o, phase_o}, {1'b1, 3'd0});
    cfg_my_id = 3'd3;

    // R9 disconnect, R2 bus reset clears owed reconnection
    do_reset();
    to_arb();
    tick(1);
    bus_busy_i = 1'b1; tgt_cd_i = 1'b1;
    tick(1);
    chk("R7 command phase", {phase_o, xfer_in_o}, {3'd4, 1'b0});
    bus_busy_i = 1'b0; tgt_cd_i = 1'b0;
    tick(1);
    chk("R9 disconnect pulse", {disc_o, done_o}, 2'b10);
    bus_rst_i = 1'b1;
    tick(1);
    bus_rst_i = 1'b0;
    bus_sel_i = 1'b1; tgt_io_i = 1'b1; bus_data_i = 8'h28;
    tick(2);
    chk("R2 reselection ignored after reset", {phase_o, busy_o}, {3'd0, 1'b0});
    idle_inputs();

    // R10 reselection ignored with nothing owed
    do_reset();
    bus_sel_i = 1'b1; tgt_io_i = 1'b1; bus_data_i = 8'h28;
    tick(2);
    chk("R10 unsolicited reselection", {phase_o, busy_o, resel_o}, {3'd0, 1'b0, 1'b0});
    idle_inputs();

    // R2 bus reset while connected
    do_reset();
    to_arb();
    tick(1);
    bus_busy_i = 1'b1; tgt_msg_i = 1'b1; tgt_cd_i = 1'b1; tgt_io_i = 1'b1;
    tick(1);
    chk("R7 message in", {phase_o, xfer_in_o}, {3'd7, 1'b1});
    bus_rst_i = 1'b1;
    tick(1);
    chk("R2 reset while connected", {phase_o, xfer_in_o}, {3'd0, 1'b0});
    bus_rst_i = 1'b0;
    idle_inputs();
    tick(1);
    chk("R2 no completion after reset", {done_o, disc_o}, 2'b00);

    // R8 status then data before release is not a completion
    do_reset();
    to_arb();
    tick(1);
    bus_busy_i = 1'b1; tgt_cd_i = 1'b1; tgt_io_i = 1'b1;
    tick(1);
    tgt_cd_i = 1'b0;
    tick(1);
    chk("R7 data in", {phase_o, xfer_in_o}, {3'd5, 1'b1});
    idle_inputs();
    tick(1);
    chk("R8 no done without final message in", {done_o, disc_o}, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule